// File: doc/BRIEF.md
# Excitation-Synchronized Windowed Sample Integrator

This block produces a slow square-wave excitation code for a DAC and, locked to that excitation, integrates a signed ADC sample stream. A short delay after every rising edge of the excitation, a window opens. The block then adds up a fixed number of valid samples and reports one signed sum for each excitation period. A typical use is a lock-in style measurement: a circuit is stimulated, and its settled response is integrated once per cycle.

All timing is expressed in sample-clock cycles through parameters. These are the period length, the delay from the rising edge to the window start, and the window length in samples. The defaults describe a 500 Hz excitation at about 247 MSPS: a 494,000-cycle period, a delay of 24,700 cycles and 50,000 samples per window. The window counts accepted samples, not clock cycles. If the sample strobe is too sparse, the window can still be open when the next rising edge arrives. In that case the window is cut at that edge, and the result is flagged as truncated.

Top module: `excite_window_integrator`

## Requirements
- R1: After reset, `excite_hi` is 0 and `dac_code` equals `LO_CODE` for the first `PERIOD/2` cycles. `excite_hi` is then 1 and `dac_code` equals `HI_CODE` for the remaining `PERIOD - PERIOD/2` cycles. This repeats with a period of exactly `PERIOD` cycles.
- R2: While `rst_n` is low at a clock edge, the block returns to the start of the low phase. After that edge, `busy`, `res_valid`, `res_trunc` and `res_sum` all read 0.
- R3: `busy` rises exactly `START_DLY` cycles after `excite_hi` rises, where 1 <= `START_DLY` <= `PERIOD`. Opening a window clears the running sum.
- R4: A sample is added to the running sum only in a cycle where `smp_vld` is 1 and `busy` already reads 1. The sample is treated as a `SAMPLE_W`-bit two's complement value.
- R5: After `WIN_LEN` samples have been accepted, the window closes and `busy` reads 0 from the next cycle on.
- R6: `res_valid` is high for exactly one cycle, the cycle after a window ends. In that cycle `res_sum` holds the exact signed sum of the accepted samples. `res_sum` and `res_trunc` then hold their values until the next result.
- R7: A window that collects all `WIN_LEN` samples reports `res_trunc` = 0. Exactly one result is produced per excitation period.
- R8: If `busy` is 1 in the cycle where `excite_hi` rises, the window ends in that cycle without taking that cycle's sample. The result reports `res_trunc` = 1 and the sum so far. If that same edge also opens the next window (`START_DLY` = 1), the new window starts from a cleared sum.
- R9: The accumulator is at least 32 bits wide and never overflows. `WIN_LEN` full-scale samples of either sign sum exactly.
- R10: Samples presented while `busy` is 0, or with `smp_vld` low, have no effect on any reported sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe: `smp_data` is valid this cycle |
| smp_data | input | SAMPLE_W | Signed ADC sample |
| excite_hi | output | 1 | Excitation level, 1 in the high half-period |
| dac_code | output | DAC_W | Excitation code for the DAC |
| busy | output | 1 | Integration window open |
| res_valid | output | 1 | One-cycle pulse: new result on `res_sum` |
| res_sum | output | max(32, SAMPLE_W+clog2(WIN_LEN+1)) | Signed window sum, held between results |
| res_trunc | output | 1 | The current result was cut at a rising edge |

## Verification
A phase counter that slips shows up within one period as an excitation edge on the wrong cycle. It also moves the `busy` rise away from its fixed distance to that edge. A sample counter or accumulator error is visible at the very next `res_valid`, as a wrong sum, a pulse on the wrong cycle or a wrong truncation flag. Checking every output on every cycle against an independent per-cycle model therefore exposes any divergent state no later than the end of the window in which it arises.

// File: rtl/exw_pkg.sv
// Package: shared types and width helpers for the windowed integrator.
// Assumes: nothing beyond standard SystemVerilog.
package exw_pkg;

    // How the window ended in the current cycle.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_FULL = 2'd1,
        END_CUT  = 2'd2
    } win_end_t;

    // Accumulator width: room for n full-scale samples, never below 32 bits.
    function automatic int acc_w(input int sw, input int n);
        int g;
        g = sw + $clog2(n + 1);
        return (g < 32) ? 32 : g;
    endfunction

endpackage

// File: rtl/exw_phase_gen.sv
// Module: excitation phase counter and square-wave code.
// Counts PERIOD cycles: low half first, then high half. Emits a rising-edge
// marker and a window-open marker placed so that the open flag, once
// registered, appears DLY cycles after the high level.
// Assumes: PERIOD >= 2 and 1 <= DLY <= PERIOD.
module exw_phase_gen #(
    parameter int PERIOD  = 494000,
    parameter int DLY     = 24700,
    parameter int DAC_W   = 16,
    parameter int HI_CODE = 49152,
    parameter int LO_CODE = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             excite_hi,
    output logic [DAC_W-1:0] dac_code,
    output logic             rise_evt,
    output logic             open_evt
);
    localparam int PW      = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int HALF    = PERIOD / 2;
    localparam int OPEN_AT = (HALF + DLY - 1) % PERIOD;
    localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
    localparam logic [PW-1:0] HALFV = PW'(HALF);
    localparam logic [PW-1:0] OPENV = PW'(OPEN_AT);

    logic [PW-1:0] pcnt;

    // Purpose: advance the phase counter, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // Purpose: decode level, DAC code and event markers from the phase.
    always_comb begin
        excite_hi = (pcnt >= HALFV);
        dac_code  = excite_hi ? DAC_W'(HI_CODE) : DAC_W'(LO_CODE);
        rise_evt  = (pcnt == HALFV);
        open_evt  = (pcnt == OPENV);
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt == LAST) |=> (pcnt == '0));
    assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= LAST);
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> !rise_evt);
endmodule

// File: rtl/exw_win_ctrl.sv
// Module: integration window control.
// Opens on open_evt, counts accepted samples and ends the window after
// WIN_LEN samples, or cuts it at a rising edge. A cut and a reopen may share
// one cycle. Assumes: WIN_LEN >= 1.
module exw_win_ctrl
    import exw_pkg::*;
#(
    parameter int WIN_LEN = 50000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise_evt,
    input  logic     open_evt,
    input  logic     smp_vld,
    output logic     busy,
    output logic     add_en,
    output logic     clr,
    output win_end_t end_kind
);
    localparam int SCW = $clog2(WIN_LEN + 1);
    localparam logic [SCW-1:0] LASTS = SCW'(WIN_LEN - 1);

    logic [SCW-1:0] scnt;
    logic           cut;
    logic           last;

    // Purpose: decide acceptance and window end for this cycle.
    always_comb begin
        cut    = busy && rise_evt;
        add_en = busy && !rise_evt && smp_vld;
        last   = add_en && (scnt == LASTS);
        clr    = open_evt;
        if (cut)       end_kind = END_CUT;
        else if (last) end_kind = END_FULL;
        else           end_kind = END_NONE;
    end

    // Purpose: track window state and accepted-sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            scnt <= '0;
        end else begin
            if (cut || last)  busy <= 1'b0;
            else if (add_en)  scnt <= scnt + 1'b1;
            if (open_evt) begin
                busy <= 1'b1;
                scnt <= '0;
            end
        end
    end

    assert_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_evt |=> busy);
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (scnt < SCW'(WIN_LEN)));
    assert_cut_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rise_evt && !open_evt) |=> !busy);
    assert_idle_no_add_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !add_en);
endmodule

// File: rtl/exw_accum.sv
// Module: signed accumulator and result register.
// Clears on clr, adds sign-extended samples on add_en, and latches the
// result with a one-cycle valid pulse when the window ends.
// Assumes: ACC_W >= SAMPLE_W.
module exw_accum
    import exw_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       add_en,
    input  win_end_t                   end_kind,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic                       res_valid,
    output logic signed [ACC_W-1:0]    res_sum,
    output logic                       res_trunc
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] nxt;

    // Purpose: running sum including the present sample.
    always_comb begin
        nxt = acc + {{(ACC_W-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data};
    end

    // Purpose: update the accumulator and latch results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            res_sum   <= '0;
            res_valid <= 1'b0;
            res_trunc <= 1'b0;
        end else begin
            res_valid <= (end_kind != END_NONE);
            if (end_kind == END_FULL) begin
                res_sum   <= nxt;
                res_trunc <= 1'b0;
            end else if (end_kind == END_CUT) begin
                res_sum   <= acc;
                res_trunc <= 1'b1;
            end
            if (clr)         acc <= '0;
            else if (add_en) acc <= nxt;
        end
    end

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_kind == END_NONE) |=> ($stable(res_sum) && $stable(res_trunc)));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/excite_window_integrator.sv
// Module: top of the excitation-synchronized windowed integrator.
// Wires the phase generator, window control and accumulator together.
// Assumes: PERIOD >= 2, 1 <= START_DLY <= PERIOD, WIN_LEN >= 1.
module excite_window_integrator
    import exw_pkg::*;
#(
    parameter int PERIOD    = 494000,
    parameter int START_DLY = 24700,
    parameter int WIN_LEN   = 50000,
    parameter int SAMPLE_W  = 16,
    parameter int DAC_W     = 16,
    parameter int HI_CODE   = 49152,
    parameter int LO_CODE   = 16384
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   smp_vld,
    input  logic signed [SAMPLE_W-1:0]                             smp_data,
    output logic                                                   excite_hi,
    output logic [DAC_W-1:0]                                       dac_code,
    output logic                                                   busy,
    output logic                                                   res_valid,
    output logic signed [exw_pkg::acc_w(SAMPLE_W, WIN_LEN)-1:0]    res_sum,
    output logic                                                   res_trunc
);
    localparam int ACC_W = acc_w(SAMPLE_W, WIN_LEN);

    logic     rise_evt;
    logic     open_evt;
    logic     add_en;
    logic     clr;
    win_end_t end_kind;

    initial begin
        assert_cfg_R3: assert (PERIOD >= 2 && START_DLY >= 1 &&
                               START_DLY <= PERIOD && WIN_LEN >= 1);
    end

    exw_phase_gen #(
        .PERIOD(PERIOD), .DLY(START_DLY), .DAC_W(DAC_W),
        .HI_CODE(HI_CODE), .LO_CODE(LO_CODE)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .excite_hi(excite_hi), .dac_code(dac_code),
        .rise_evt(rise_evt), .open_evt(open_evt)
    );

    exw_win_ctrl #(.WIN_LEN(WIN_LEN)) u_win (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .open_evt(open_evt),
        .smp_vld(smp_vld), .busy(busy), .add_en(add_en), .clr(clr),
        .end_kind(end_kind)
    );

    exw_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(add_en),
        .end_kind(end_kind), .smp_data(smp_data), .res_valid(res_valid),
        .res_sum(res_sum), .res_trunc(res_trunc)
    );

    assert_busy_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> excite_hi || (START_DLY > PERIOD - PERIOD/2));
endmodule

// File: tb/test_excite_window_integrator.sv
module test_excite_window_integrator;
    localparam int NI = 2;
    localparam int PER [NI] = '{40, 40};
    localparam int DLY [NI] = '{3, 1};
    localparam int WIN [NI] = '{8, 40};
    localparam int HI = 49152;
    localparam int LO = 16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [15:0] smp_data = '0;

    logic               ex   [NI];
    logic [15:0]        dac  [NI];
    logic               bsy  [NI];
    logic               rv   [NI];
    logic signed [31:0] sum  [NI];
    logic               tr   [NI];

    int checks = 0;
    int errors = 0;
    int phase_id = 0;

    int      m_p   [NI];
    bit      m_open[NI];
    int      m_cnt [NI];
    longint  m_acc [NI];
    longint  m_sum [NI];
    bit      m_rv  [NI];
    bit      m_err [NI];

    always #2 clk = ~clk;

    excite_window_integrator #(.PERIOD(40), .START_DLY(3), .WIN_LEN(8)) i_excite_window_integrator (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .excite_hi(ex[0]), .dac_code(dac[0]), .busy(bsy[0]), .res_valid(rv[0]),
        .res_sum(sum[0]), .res_trunc(tr[0]));

    excite_window_integrator #(.PERIOD(40), .START_DLY(1), .WIN_LEN(40)) i_excite_window_integrator_cut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .excite_hi(ex[1]), .dac_code(dac[1]), .busy(bsy[1]), .res_valid(rv[1]),
        .res_sum(sum[1]), .res_trunc(tr[1]));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NI; i++) begin
            m_p[i] = 0; m_open[i] = 0; m_cnt[i] = 0;
            m_acc[i] = 0; m_sum[i] = 0; m_rv[i] = 0; m_err[i] = 0;
        end
    endfunction

    // Expected output level from the phase (R1).
    function automatic bit exp_hi(input int i);
        return m_p[i] >= PER[i] / 2;
    endfunction

    function automatic void model_step(input bit v, input longint d);
        for (int i = 0; i < NI; i++) begin
            bit rise;
            bit opn;
            rise = (m_p[i] == PER[i] / 2);
            opn  = (m_p[i] == (PER[i] / 2 + DLY[i] - 1) % PER[i]);
            m_rv[i] = 0;
            if (m_open[i] && rise) begin
                m_open[i] = 0; m_sum[i] = m_acc[i]; m_err[i] = 1; m_rv[i] = 1;
            end else if (m_open[i] && v) begin
                m_acc[i] += d;
                m_cnt[i]++;
                if (m_cnt[i] == WIN[i]) begin
                    m_open[i] = 0; m_sum[i] = m_acc[i]; m_err[i] = 0; m_rv[i] = 1;
                end
            end
            if (opn) begin
                m_open[i] = 1; m_cnt[i] = 0; m_acc[i] = 0;
            end
            m_p[i] = (m_p[i] + 1) % PER[i];
        end
    endfunction

    task automatic check_outputs();
        for (int i = 0; i < NI; i++) begin
            string sreq;
            chk("R1 excite_hi", ex[i], exp_hi(i));
            chk("R1 dac_code", dac[i], exp_hi(i) ? HI : LO);
            chk("R3/R5 busy", bsy[i], m_open[i]);
            chk("R6 res_valid", rv[i], m_rv[i]);
            if (m_rv[i]) begin
                if (m_err[i])        sreq = "R8 truncated sum";
                else if (phase_id == 3 || phase_id == 4) sreq = "R9 full-scale sum";
                else if (phase_id == 2) sreq = "R10 sparse-valid sum";
                else                 sreq = "R4 window sum";
                chk(sreq, sum[i], m_sum[i]);
                chk(m_err[i] ? "R8 trunc flag" : "R7 trunc flag", tr[i], m_err[i]);
            end
        end
    endtask

    task automatic check_reset_state();
        for (int i = 0; i < NI; i++) begin
            chk("R2 busy", bsy[i], 0);
            chk("R2 res_valid", rv[i], 0);
            chk("R2 res_sum", sum[i], 0);
            chk("R2 res_trunc", tr[i], 0);
            chk("R2 excite low", ex[i], 0);
        end
    endtask

    // One cycle: check at negedge, drive, advance model, move to next negedge.
    task automatic cycle(input bit r, input bit v, input logic signed [15:0] d);
        check_outputs();
        rst_n    = r;
        smp_vld  = v;
        smp_data = d;
        if (!r) model_reset();
        else    model_step(v, longint'(d));
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int res_count;
        void'($urandom(32'd7031));
        model_reset();
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        // Phase 0: dense valid, random data (R4, R5, R6, R7).
        phase_id = 0;
        for (int c = 0; c < 400; c++) cycle(1, 1, 16'($urandom));
        // Phase 1: about half valid (R4, R8 on the long window).
        phase_id = 1;
        for (int c = 0; c < 400; c++) cycle(1, ($urandom % 2) == 0, 16'($urandom));
        // Phase 2: sparse valid, loud data when invalid (R10).
        phase_id = 2;
        for (int c = 0; c < 400; c++) begin
            bit v;
            v = ($urandom % 8) == 0;
            cycle(1, v, v ? 16'($urandom % 100) : 16'sh7fff);
        end
        // Phase 3/4: full-scale extremes (R9).
        phase_id = 3;
        for (int c = 0; c < 200; c++) cycle(1, 1, 16'sh8000);
        phase_id = 4;
        for (int c = 0; c < 200; c++) cycle(1, 1, 16'sh7fff);
        // Mid-run reset (R2) then restart.
        phase_id = 0;
        for (int c = 0; c < 3; c++) cycle(0, 1, 16'sh1234);
        check_reset_state();
        res_count = 0;
        for (int c = 0; c < 160; c++) begin
            if (rv[0]) res_count++;
            cycle(1, 1, 16'($urandom));
        end
        // R7: four periods of the short window give four results.
        chk("R7 results per period", res_count, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule